// File: doc/BRIEF.md
# UART Automatic Baud Rate Detector

This block finds the bit rate of an incoming asynchronous serial stream without prior configuration. Software arms it, and the far end then sends a single upper- or lower-case letter A. The block times the low start bit of that character in reference-clock cycles. From that measurement it derives a divisor for 16x oversampling. It then receives the rest of the character with the new divisor. A lock is declared only if the character is one of the two accepted letters and its stop bit is high.

The detector retries on its own until it locks, for as long as detection is requested. Once it has locked, the request bit no longer matters, and later characters are received with the computed divisor. An active-low interrupt reports the lock and is removed by reading the captured character. The divisor register also has a write port, and that port takes priority over the detector. The fastest rate the block can lock to is one sixteenth of the reference clock, which gives a divisor of 1.

Top module: `uart_autobaud`

## Requirements
- R1: `detDone` rises only after a frame whose 8 data bits (received LSB first, no parity) equal 0x41 or 0x61 and whose single stop bit is sampled high. Any other character, or a low stop bit, leaves `detDone` at 0.
- R2: While detection is requested and `detDone` is 0, each failed attempt re-arms the detector. The next falling edge on `rxIn` starts a fresh attempt.
- R3: Once `detDone` is 1, clearing the request bit changes neither `detDone` nor reception. Later frames are still received with the current divisor and loaded into `rxChar` when their stop bit is high.
- R4: `irqN` is 0 exactly when `detDone`, the request bit and `irqEn` are all 1 and the locked character has not been read. A one-cycle `rdAck` pulse counts as the read and returns `irqN` to 1.
- R5: `baudCount` resets to 8 and is reloaded to 8 by an arming write. A start bit that holds the line low for B cycles leaves `baudCount` at 8+B. The count saturates at 0xFFFF.
- R6: `baudCount` changes only while a start bit is measured under an active request. It holds its value after the measurement, and while the request bit is 0, until the next arming write or attempt.
- R7: A `wrEn` write loads `wrData` into `divisor`, and this wins over a detector update in the same cycle.
- R8: After a measurement, `divisor` equals `baudCount` shifted right by 4 (that is, (B+8)/16 truncated), with 0 replaced by 1. A 16-cycle start bit gives divisor 1, the fastest rate, at one sixteenth of the reference clock.
- R9: A `ctlWr` pulse writes the request bit from `ctlReq`. A 0 on `ctlDone` clears `detDone`. A write that leaves the request at 1 and `detDone` at 0 arms a new sequence.
- R10: `rxChar` holds the last character that was accepted, and resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxIn | input | 1 | Serial receive line, idle high |
| ctlWr | input | 1 | Control write strobe |
| ctlReq | input | 1 | Detect-request value written by ctlWr |
| ctlDone | input | 1 | Detect-done value written by ctlWr (0 clears) |
| irqEn | input | 1 | Lock interrupt enable |
| rdAck | input | 1 | Pulse: captured character has been read |
| wrEn | input | 1 | Divisor register write strobe |
| wrData | input | 12 | Divisor write value |
| divisor | output | 12 | Oversampling divisor in reference cycles per tick |
| baudCount | output | 16 | Raw start-bit count |
| detDone | output | 1 | Detection complete flag |
| irqN | output | 1 | Active-low lock interrupt |
| rxChar | output | 8 | Last accepted character |

## Verification
The bench aims at the characters that should not lock: letters other than A and a that still have bit 0 set, so the start bit is measured correctly, and an A with a low stop bit. A design that skipped the match or the frame check would report a lock on these. It drives a 16-cycle start bit, which a divisor off by one or left unclamped at zero would fail to receive. It holds the line low long enough to saturate the count, where a design without the stop at 0xFFFF wraps back to small values. A bus write that lands on the cycle the divisor is latched must survive, and one that loses leaves the measured value in place. The bench also drops the request after a lock and then receives another character, and it toggles the enable and the read around the interrupt.

// File: rtl/autobaud_pkg.sv
package autobaud_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_MEAS,
    ST_RECV,
    ST_LOCKED
  } abState_t;

  // strobes from the control FSM into the datapath
  typedef struct packed {
    logic cntArm;    // reload start-bit count to half a bit
    logic cntEdge;   // reload count at a falling edge, counting that cycle
    logic cntInc;    // count one more low cycle
    logic divLatch;  // take divisor from measured count
    logic rxStart;   // restart bit timing
    logic rxLong;    // first sample 1.5 bits away (start edge) instead of 0.5
    logic rxRun;     // bit timing active
    logic charLoad;  // copy shift register into character register
  } dpCmd_t;

endpackage

// File: rtl/autobaud_dp.sv
module autobaud_dp
  import autobaud_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int OSR_LG = 4,
  parameter int CHAR_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      rxIn,
  input  dpCmd_t                    cmd,
  input  logic                      wrEn,
  input  logic [CNT_W-OSR_LG-1:0]   wrData,
  output logic                      rxS,
  output logic                      fallEdge,
  output logic                      sampleNow,
  output logic                      stopPhase,
  output logic [CHAR_W-1:0]         frameByte,
  output logic [CNT_W-1:0]          baudCount,
  output logic [CNT_W-OSR_LG-1:0]   divisor,
  output logic [CHAR_W-1:0]         rxChar
);

  localparam int DIV_W = CNT_W - OSR_LG;
  localparam int OSR   = 1 << OSR_LG;
  localparam int HALF  = OSR / 2;
  localparam int TK_W  = $clog2(OSR + HALF + 1);
  localparam int BI_W  = $clog2(CHAR_W + 1);

  logic              rxMeta, rxPrev;
  logic [CNT_W-1:0]  cnt;
  logic [DIV_W-1:0]  divReg, divCalc, divNext, divCnt;
  logic [DIV_W:0]    divCntP1;
  logic              tick;
  logic [TK_W-1:0]   ticksLeft;
  logic [BI_W-1:0]   bitIdx;
  logic [CHAR_W-1:0] shReg, charReg;

  // two-stage synchroniser, plus one stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxS    <= 1'b1;
      rxPrev <= 1'b1;
    end else begin
      rxMeta <= rxIn;
      rxS    <= rxMeta;
      rxPrev <= rxS;
    end
  end

  assign fallEdge = rxPrev & ~rxS;

  // start-bit counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= CNT_W'(HALF);
    else if (cmd.cntArm)    cnt <= CNT_W'(HALF);
    else if (cmd.cntEdge)   cnt <= CNT_W'(HALF + 1);
    else if (cmd.cntInc && cnt != {CNT_W{1'b1}})
                            cnt <= cnt + 1'b1;
  end

  a_r5_cnt_sat: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == {CNT_W{1'b1}} && !cmd.cntArm && !cmd.cntEdge) |=> cnt == {CNT_W{1'b1}});

  a_r6_cnt_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.cntArm || cmd.cntEdge || cmd.cntInc) |=> $stable(cnt));

  // divisor register: bus write has priority over detection
  assign divCalc = cnt[CNT_W-1:OSR_LG];
  assign divNext = (divCalc == '0) ? DIV_W'(1) : divCalc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             divReg <= DIV_W'(1);
    else if (wrEn)         divReg <= wrData;
    else if (cmd.divLatch) divReg <= divNext;
  end

  a_r7_bus_wins: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> divReg == $past(wrData));

  a_r8_div_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.divLatch && !wrEn) |=> divReg != '0);

  // oversampling tick generator
  assign divCntP1 = {1'b0, divCnt} + 1'b1;
  assign tick     = divCntP1 >= {1'b0, divReg};

  assign stopPhase = (bitIdx == BI_W'(CHAR_W));
  assign sampleNow = cmd.rxRun && tick && (ticksLeft == TK_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt    <= '0;
      ticksLeft <= '0;
      bitIdx    <= '0;
      shReg     <= '0;
    end else if (cmd.rxStart) begin
      divCnt    <= '0;
      ticksLeft <= cmd.rxLong ? TK_W'(HALF + OSR) : TK_W'(HALF);
      bitIdx    <= '0;
    end else if (cmd.rxRun) begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) begin
        if (ticksLeft == TK_W'(1)) begin
          ticksLeft <= TK_W'(OSR);
          if (!stopPhase) begin
            shReg  <= {rxS, shReg[CHAR_W-1:1]};
            bitIdx <= bitIdx + 1'b1;
          end
        end else begin
          ticksLeft <= ticksLeft - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             charReg <= '0;
    else if (cmd.charLoad) charReg <= shReg;
  end

  assign frameByte = shReg;
  assign baudCount = cnt;
  assign divisor   = divReg;
  assign rxChar    = charReg;

endmodule

// File: rtl/autobaud_ctrl.sv
module autobaud_ctrl
  import autobaud_pkg::*;
#(
  parameter int          CHAR_W   = 8,
  parameter logic [7:0]  MATCH_UP = 8'h41,
  parameter logic [7:0]  MATCH_LO = 8'h61
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWr,
  input  logic              ctlReq,
  input  logic              ctlDone,
  input  logic              irqEn,
  input  logic              rdAck,
  input  logic              rxS,
  input  logic              fallEdge,
  input  logic              sampleNow,
  input  logic              stopPhase,
  input  logic [CHAR_W-1:0] frameByte,
  output dpCmd_t            cmd,
  output logic              detDone,
  output logic              irqN
);

  abState_t state, stNext;
  logic     reqBit, doneBit, pendBit;
  logic     armWrite, clrWrite, setDone, matchOk;

  assign clrWrite = ctlWr && !ctlDone;
  assign armWrite = ctlWr && ctlReq && !(doneBit && ctlDone);
  assign matchOk  = rxS && (frameByte == CHAR_W'(MATCH_UP) || frameByte == CHAR_W'(MATCH_LO));

  always_comb begin
    cmd     = '0;
    stNext  = state;
    setDone = 1'b0;
    if (armWrite) begin
      cmd.cntArm = 1'b1;
      stNext     = ST_ARMED;
    end else if (ctlWr && !ctlReq && !ctlDone) begin
      stNext = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: stNext = ST_IDLE;
        ST_ARMED: begin
          if (!reqBit) stNext = ST_IDLE;
          else if (fallEdge) begin
            cmd.cntEdge = 1'b1;
            stNext      = ST_MEAS;
          end
        end
        ST_MEAS: begin
          if (!reqBit) stNext = ST_IDLE;
          else if (rxS) begin
            cmd.divLatch = 1'b1;
            cmd.rxStart  = 1'b1;
            stNext       = ST_RECV;
          end else begin
            cmd.cntInc = 1'b1;
          end
        end
        ST_RECV: begin
          cmd.rxRun = 1'b1;
          if (!doneBit && !reqBit) begin
            stNext = ST_IDLE;
          end else if (sampleNow && stopPhase) begin
            if (doneBit) begin
              cmd.charLoad = rxS;
              stNext       = ST_LOCKED;
            end else if (matchOk) begin
              cmd.charLoad = 1'b1;
              setDone      = 1'b1;
              stNext       = ST_LOCKED;
            end else begin
              stNext = ST_ARMED;   // retry on the next start bit
            end
          end
        end
        ST_LOCKED: begin
          if (fallEdge) begin
            cmd.rxStart = 1'b1;
            cmd.rxLong  = 1'b1;
            stNext      = ST_RECV;
          end
        end
        default: stNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      reqBit  <= 1'b0;
      doneBit <= 1'b0;
      pendBit <= 1'b0;
    end else begin
      state <= stNext;
      if (ctlWr) reqBit <= ctlReq;
      if (clrWrite)     doneBit <= 1'b0;
      else if (setDone) doneBit <= 1'b1;
      if (clrWrite || armWrite) pendBit <= 1'b0;
      else if (setDone)         pendBit <= 1'b1;
      else if (rdAck)           pendBit <= 1'b0;
    end
  end

  assign detDone = doneBit;
  assign irqN    = !(doneBit && reqBit && irqEn && pendBit);

  a_r1_done_on_match: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneBit) |-> $past(sampleNow && stopPhase && matchOk));

  a_r3_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (doneBit && !clrWrite) |=> doneBit);

  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rdAck && !setDone) |=> irqN);

  a_r2_retry_armed: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECV && !doneBit && reqBit && sampleNow && stopPhase && !matchOk && !ctlWr)
      |=> state == ST_ARMED);

endmodule

// File: rtl/uart_autobaud.sv
module uart_autobaud #(
  parameter int CNT_W  = 16,
  parameter int OSR_LG = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    rxIn,
  input  logic                    ctlWr,
  input  logic                    ctlReq,
  input  logic                    ctlDone,
  input  logic                    irqEn,
  input  logic                    rdAck,
  input  logic                    wrEn,
  input  logic [CNT_W-OSR_LG-1:0] wrData,
  output logic [CNT_W-OSR_LG-1:0] divisor,
  output logic [CNT_W-1:0]        baudCount,
  output logic                    detDone,
  output logic                    irqN,
  output logic [7:0]              rxChar
);

  localparam int CHAR_W = 8;

  autobaud_pkg::dpCmd_t cmd;
  logic              rxS, fallEdge, sampleNow, stopPhase;
  logic [CHAR_W-1:0] frameByte;

  autobaud_ctrl #(.CHAR_W(CHAR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ctlWr     (ctlWr),
    .ctlReq    (ctlReq),
    .ctlDone   (ctlDone),
    .irqEn     (irqEn),
    .rdAck     (rdAck),
    .rxS       (rxS),
    .fallEdge  (fallEdge),
    .sampleNow (sampleNow),
    .stopPhase (stopPhase),
    .frameByte (frameByte),
    .cmd       (cmd),
    .detDone   (detDone),
    .irqN      (irqN)
  );

  autobaud_dp #(.CNT_W(CNT_W), .OSR_LG(OSR_LG), .CHAR_W(CHAR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .rxIn      (rxIn),
    .cmd       (cmd),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .rxS       (rxS),
    .fallEdge  (fallEdge),
    .sampleNow (sampleNow),
    .stopPhase (stopPhase),
    .frameByte (frameByte),
    .baudCount (baudCount),
    .divisor   (divisor),
    .rxChar    (rxChar)
  );

endmodule

// File: tb/uart_autobaud_test.sv
`timescale 1ns/1ps
module uart_autobaud_test;

  localparam int DIV_W = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxIn = 1'b1;
  logic ctlWr = 1'b0, ctlReq = 1'b0, ctlDone = 1'b0;
  logic irqEn = 1'b0, rdAck = 1'b0, wrEn = 1'b0;
  logic [DIV_W-1:0] wrData = '0;
  logic [DIV_W-1:0] divisor;
  logic [15:0]      baudCount;
  logic             detDone, irqN;
  logic [7:0]       rxChar;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  uart_autobaud uut (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .ctlWr(ctlWr), .ctlReq(ctlReq),
    .ctlDone(ctlDone), .irqEn(irqEn), .rdAck(rdAck), .wrEn(wrEn), .wrData(wrData),
    .divisor(divisor), .baudCount(baudCount), .detDone(detDone), .irqN(irqN),
    .rxChar(rxChar)
  );

  function automatic int expCount(int b);
    return (b + 8 > 65535) ? 65535 : b + 8;
  endfunction

  function automatic int expDiv(int b);
    int d = expCount(b) >> 4;
    return (d == 0) ? 1 : d;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ctlWrite(bit rq, bit dn);
    @(negedge clk);
    ctlWr = 1'b1; ctlReq = rq; ctlDone = dn;
    @(negedge clk);
    ctlWr = 1'b0;
  endtask

  task automatic sendFrame(logic [7:0] c, int b, bit stopV, int busVal);
    rxIn = 1'b0;
    repeat (b) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxIn = c[i];
      if (i == 0 && busVal >= 0) begin
        wrEn = 1'b1; wrData = DIV_W'(busVal);
        repeat (6) @(negedge clk);
        wrEn = 1'b0;
        repeat (b - 6) @(negedge clk);
      end else begin
        repeat (b) @(negedge clk);
      end
    end
    rxIn = stopV;
    repeat (b) @(negedge clk);
    rxIn = 1'b1;
    repeat (2 * b + 4) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    check("R5 reset count", baudCount, 8);
    check("R8 reset divisor", divisor, 1);
    check("R1 reset done", detDone, 0);
    check("R4 reset irq", irqN, 1);
    check("R10 reset char", rxChar, 0);

    // basic lock on 'A'
    irqEn = 1'b1;
    ctlWrite(1, 0);
    check("R9 armed count", baudCount, 8);
    sendFrame(8'h41, 160, 1, -1);
    check("R1 lock A", detDone, 1);
    check("R8 divisor 160", divisor, 10);
    check("R5 count 160", baudCount, 168);
    check("R10 char A", rxChar, 8'h41);
    check("R4 irq active", irqN, 0);

    // interrupt enable and read
    irqEn = 1'b0; @(negedge clk);
    check("R4 irq masked", irqN, 1);
    irqEn = 1'b1; @(negedge clk);
    check("R4 irq unmasked", irqN, 0);
    rdAck = 1'b1; @(negedge clk); rdAck = 1'b0; @(negedge clk);
    check("R4 read clears", irqN, 1);

    // request ignored after lock, reception continues
    ctlWrite(0, 1);
    check("R3 done kept", detDone, 1);
    sendFrame(8'h5A, 160, 1, -1);
    check("R3 char after lock", rxChar, 8'h5A);
    check("R3 done after frame", detDone, 1);
    check("R6 count held", baudCount, 168);

    // no counting without request
    ctlWrite(1, 0);
    check("R9 rearm count", baudCount, 8);
    check("R9 rearm done", detDone, 0);
    ctlWrite(0, 1);
    rxIn = 1'b0; repeat (100) @(negedge clk); rxIn = 1'b1; repeat (10) @(negedge clk);
    check("R6 no count idle", baudCount, 8);
    check("R6 no lock idle", detDone, 0);

    // retry after wrong character and framing error
    ctlWrite(1, 0);
    sendFrame(8'h43, 96, 1, -1);
    check("R1 wrong char", detDone, 0);
    check("R5 count 96", baudCount, 104);
    sendFrame(8'h41, 96, 0, -1);
    check("R1 framing error", detDone, 0);
    sendFrame(8'h61, 96, 1, -1);
    check("R2 retry locks", detDone, 1);
    check("R10 char a", rxChar, 8'h61);
    check("R8 divisor 96", divisor, 6);

    // bus write collides with divisor latch
    ctlWrite(1, 0);
    sendFrame(8'h41, 320, 1, 21);
    check("R7 bus wins", divisor, 21);
    check("R7 lock with bus divisor", detDone, 1);

    // fastest rate and an uneven bit length
    ctlWrite(1, 0);
    sendFrame(8'h41, 16, 1, -1);
    check("R8 max rate div", divisor, 1);
    check("R8 max rate lock", detDone, 1);
    check("R5 count 16", baudCount, 24);
    ctlWrite(1, 0);
    sendFrame(8'h61, 200, 1, -1);
    check("R8 uneven div", divisor, 13);
    check("R5 uneven count", baudCount, 208);
    check("R1 uneven lock", detDone, 1);

    // random frames
    for (int it = 0; it < 16; it++) begin
      int k = 1 + int'($urandom % 20);
      int b = 16 * k;
      int sel = int'($urandom % 4);
      logic [7:0] c;
      bit stopV = 1'b1;
      bit expD;
      if (sel == 0) c = 8'h41;
      else if (sel == 1) c = 8'h61;
      else if (sel == 2) begin
        c = 8'($urandom % 256) | 8'h01;
        if (c == 8'h41 || c == 8'h61) c = c ^ 8'h02;
      end else begin
        c = 8'h41; stopV = 1'b0;
      end
      expD = (sel < 2);
      ctlWrite(1, 0);
      sendFrame(c, b, stopV, -1);
      check("R1 random done", detDone, expD);
      check("R5 random count", baudCount, expCount(b));
      check("R8 random div", divisor, expDiv(b));
      if (expD) check("R10 random char", rxChar, c);
    end

    // saturation of the start-bit count
    ctlWrite(1, 0);
    rxIn = 1'b0;
    repeat (65600) @(negedge clk);
    check("R5 saturate", baudCount, 16'hFFFF);
    rxIn = 1'b1;
    repeat (10) @(negedge clk);
    ctlWrite(1, 0);
    check("R5 reload after sat", baudCount, 8);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule